// File: doc/BRIEF.md
# CPU/PCI Clock Divider with Synchronous Stop Gating

This block turns one fast CPU-domain input clock into two CPU clock outputs and six PCI clock outputs. The CPU outputs carry the input clock itself through a falling-edge enable. The PCI outputs all come from one shared integer divider. A frequency-select input sets the divide ratio: 2 for the lower CPU setting and 3 for the higher one. A new ratio takes effect only when the divider counter wraps to zero.

Three active-high controls manage power: CPU stop, PCI stop and power-down. Each passes through a two-flop synchronizer and then drives a group enable. That enable changes only while its group's clock is LOW, so an output parks LOW after a full HIGH phase and restarts with a full HIGH phase. PCI output bit 0 is free-running: PCI stop does not affect it, but power-down does. Stop gating never resets the divider, so all PCI outputs stay phase-aligned.

All pins are plain control and clock pins. No data flows through the block, so there is no handshake at its edge.

Top module: `cpu_pci_clkgen`

## Requirements
- R1: While synchronous reset `rst` is high, every CPU and PCI output is LOW after the next clock edges, and the divider counter is cleared.
- R2: With `sel_fast` = 0, every running PCI output repeats with a period of 2 input cycles: 1 cycle HIGH, then 1 cycle LOW.
- R3: With `sel_fast` = 1, every running PCI output repeats with a period of 3 input cycles: 1 cycle HIGH, then 2 cycles LOW.
- R4: A change of `sel_fast` takes effect only when the divider counter is at zero. The counter never goes past the last value of the active ratio, and no PCI output is ever HIGH for two input cycles in a row.
- R5: While `cpu_stop` is held, both `cpu_clk_o` bits stay LOW. The PCI outputs are not affected.
- R6: While `pci_stop` is held, `pci_clk_o[5:1]` stay LOW and `pci_clk_o[0]` keeps toggling at the selected ratio.
- R7: While `pwr_down` is held, all eight outputs stay LOW, `pci_clk_o[0]` included.
- R8: Each control acts only after two input-clock edges of synchronization. A CPU output keeps its full HIGH phase through any gating change, and a PCI HIGH pulse always lasts exactly one input cycle.
- R9: All PCI outputs come from one divider. Whenever any stoppable PCI output is HIGH, `pci_clk_o[0]` is HIGH in that same cycle.
- R10: When a stop control is released, the affected outputs resume at the selected ratio, and their first pulse is a full-width pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast CPU-domain input clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_fast | input | 1 | 0: PCI = clk/2; 1: PCI = clk/3 |
| cpu_stop | input | 1 | Asynchronous request to park the CPU outputs LOW |
| pci_stop | input | 1 | Asynchronous request to park PCI bits 5..1 LOW |
| pwr_down | input | 1 | Asynchronous request to park every output LOW |
| cpu_clk_o | output | 2 | Gated CPU clock outputs |
| pci_clk_o | output | 6 | PCI clock outputs; bit 0 is free-running |

## Verification
The assertions assume that each stop control stays at one level for several cycles. The parking checks only become active after a control has been held for a minimum run, counted by saturating counters in the checker. They also assume `sel_fast` is quasi-static compared with the divider period. The stimulus meets both assumptions: it changes the controls only while `clk` is LOW and then holds each setting for at least a dozen cycles before it measures. Ratio changes happen mid-run, so the wrap-only update of the ratio is still exercised.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int CPU_OUTS = 2;
  localparam int PCI_OUTS = 6;
  localparam int DIV_SLOW = 2;
  localparam int DIV_FAST = 3;
  localparam int CNT_W    = $clog2(DIV_FAST + 1);

  typedef enum logic [1:0] {
    CTL_CPU_STOP = 2'd0,
    CTL_PCI_STOP = 2'd1,
    CTL_PWR_DOWN = 2'd2
  } ctl_idx_e;
endpackage

// File: rtl/sync2.sv
module sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pci_divider.sv
module pci_divider #(
  parameter int DIV_LO = 2,
  parameter int DIV_HI = 3,
  parameter int CW     = $clog2(DIV_HI + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_hi,
  output logic          pulse_nx,
  output logic          pulse_q,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] ratio_q
);
  localparam logic [CW-1:0] R_LO = CW'(DIV_LO);
  localparam logic [CW-1:0] R_HI = CW'(DIV_HI);

  logic          wrap;
  logic [CW-1:0] cnt_nx;

  // the counter wraps on the last value of the active ratio
  assign wrap     = (cnt_q == ratio_q - CW'(1));
  assign cnt_nx   = wrap ? '0 : cnt_q + CW'(1);
  assign pulse_nx = (cnt_nx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      ratio_q <= R_LO;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_nx;
      pulse_q <= pulse_nx;
      // a new ratio is loaded only at the wrap, so it starts from count zero
      if (wrap) ratio_q <= sel_hi ? R_HI : R_LO;
    end
  end
endmodule

// File: rtl/pci_gate.sv
module pci_gate #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pulse_nx,
  input  logic         pulse_q,
  input  logic [N-1:0] allow,
  output logic [N-1:0] out
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_lane
      logic en_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          en_q <= 1'b0;
          out[i] <= 1'b0;
        end else begin
          // the enable moves only at the edge that ends a HIGH pulse
          if (pulse_q) en_q <= allow[i];
          out[i] <= pulse_nx & en_q;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/cpu_gate.sv
module cpu_gate #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         allow,
  output logic [N-1:0] out
);
  logic en_q;

  // the enable changes while clk is LOW, so a HIGH phase is never cut short
  always_ff @(negedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= allow;
  end

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_out
      assign out[i] = clk & en_q;
    end
  endgenerate
endmodule

// File: rtl/cpu_pci_clkgen.sv
module cpu_pci_clkgen
  import clkgen_pkg::*;
#(
  parameter int N_CPU  = CPU_OUTS,
  parameter int N_PCI  = PCI_OUTS,
  parameter int DIV_LO = DIV_SLOW,
  parameter int DIV_HI = DIV_FAST
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_fast,
  input  logic             cpu_stop,
  input  logic             pci_stop,
  input  logic             pwr_down,
  output logic [N_CPU-1:0] cpu_clk_o,
  output logic [N_PCI-1:0] pci_clk_o
);
  localparam int CW = $clog2(DIV_HI + 1);

  logic [3:0]       ctl_raw, ctl_s;
  logic             sel_s;
  logic             pulse_nx, pulse_q;
  logic [CW-1:0]    div_cnt, div_ratio;
  logic [N_PCI-1:0] pci_allow;

  assign ctl_raw = {sel_fast, pwr_down, pci_stop, cpu_stop};

  sync2 #(.W(4)) u_sync (
    .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s)
  );
  assign sel_s = ctl_s[3];

  pci_divider #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI), .CW(CW)) u_div (
    .clk(clk), .rst(rst), .sel_hi(sel_s),
    .pulse_nx(pulse_nx), .pulse_q(pulse_q),
    .cnt_q(div_cnt), .ratio_q(div_ratio)
  );

  // bit 0 ignores pci_stop; every bit obeys power-down
  genvar i;
  generate
    for (i = 0; i < N_PCI; i++) begin : g_allow
      if (i == 0) begin : g_free
        assign pci_allow[i] = ~ctl_s[CTL_PWR_DOWN];
      end else begin : g_stop
        assign pci_allow[i] = ~(ctl_s[CTL_PWR_DOWN] | ctl_s[CTL_PCI_STOP]);
      end
    end
  endgenerate

  pci_gate #(.N(N_PCI)) u_pci (
    .clk(clk), .rst(rst), .pulse_nx(pulse_nx), .pulse_q(pulse_q),
    .allow(pci_allow), .out(pci_clk_o)
  );

  cpu_gate #(.N(N_CPU)) u_cpu (
    .clk(clk), .rst(rst),
    .allow(~(ctl_s[CTL_PWR_DOWN] | ctl_s[CTL_CPU_STOP])),
    .out(cpu_clk_o)
  );
endmodule

// File: rtl/cpu_pci_clkgen_chk.sv
module cpu_pci_clkgen_chk #(
  parameter int N_CPU = 2,
  parameter int N_PCI = 6,
  parameter int CW    = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             cpu_stop,
  input logic             pci_stop,
  input logic             pwr_down,
  input logic [N_CPU-1:0] cpu_clk_o,
  input logic [N_PCI-1:0] pci_clk_o,
  input logic [CW-1:0]    div_cnt,
  input logic [CW-1:0]    div_ratio
);
  logic [2:0] cs_run, ps_run, pd_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_run <= '0; ps_run <= '0; pd_run <= '0;
    end else begin
      cs_run <= !cpu_stop ? 3'd0 : (cs_run == 3'd7) ? cs_run : cs_run + 3'd1;
      ps_run <= !pci_stop ? 3'd0 : (ps_run == 3'd7) ? ps_run : ps_run + 3'd1;
      pd_run <= !pwr_down ? 3'd0 : (pd_run == 3'd7) ? pd_run : pd_run + 3'd1;
    end
  end

  assert_pulse_width_R8: assert property (@(posedge clk) disable iff (rst)
    (pci_clk_o != '0) |=> ((pci_clk_o & $past(pci_clk_o)) == '0));

  assert_counter_range_R4: assert property (@(posedge clk) disable iff (rst)
    div_cnt < div_ratio);

  assert_phase_aligned_R9: assert property (@(posedge clk) disable iff (rst)
    (pci_clk_o[N_PCI-1:1] != '0) |-> pci_clk_o[0]);

  assert_pci_parked_R6: assert property (@(posedge clk) disable iff (rst)
    (ps_run >= 3'd6) |-> (pci_clk_o[N_PCI-1:1] == '0));

  assert_all_parked_R7: assert property (@(posedge clk) disable iff (rst)
    (pd_run >= 3'd6) |-> (pci_clk_o == '0));

  assert_cpu_parked_R5: assert property (@(negedge clk) disable iff (rst)
    (cs_run >= 3'd4) |-> (cpu_clk_o == '0));
endmodule

bind cpu_pci_clkgen cpu_pci_clkgen_chk #(.N_CPU(N_CPU), .N_PCI(N_PCI), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .cpu_stop(cpu_stop), .pci_stop(pci_stop),
  .pwr_down(pwr_down), .cpu_clk_o(cpu_clk_o), .pci_clk_o(pci_clk_o),
  .div_cnt(div_cnt), .div_ratio(div_ratio)
);

// File: tb/sim_cpu_pci_clkgen.sv
module sim_cpu_pci_clkgen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_fast = 1'b0, cpu_stop = 1'b0, pci_stop = 1'b0, pwr_down = 1'b0;
  logic [1:0] cpu_clk_o;
  logic [5:0] pci_clk_o;

  int tests = 0;
  int fails = 0;
  int runts = 0;
  int doubles = 0;
  bit mon_on = 1'b0;
  logic [5:0] prev_pci = '0;

  always #10 clk = ~clk;  // 50 MHz

  cpu_pci_clkgen u0 (
    .clk(clk), .rst(rst), .sel_fast(sel_fast), .cpu_stop(cpu_stop),
    .pci_stop(pci_stop), .pwr_down(pwr_down),
    .cpu_clk_o(cpu_clk_o), .pci_clk_o(pci_clk_o)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #5;
  endtask

  task automatic drive(input logic s, input logic cs, input logic ps, input logic pd);
    @(negedge clk); #2;
    sel_fast = s; cpu_stop = cs; pci_stop = ps; pwr_down = pd;
  endtask

  // runt and double-pulse monitor (R8)
  always @(posedge clk) begin
    logic [1:0] early;
    #2 early = cpu_clk_o;
    #6;
    if (mon_on && (cpu_clk_o != early)) runts++;
    if (mon_on && ((pci_clk_o & prev_pci) != '0)) doubles++;
    prev_pci = pci_clk_o;
  end

  // {sel_fast, cpu_stop, pci_stop, pwr_down}
  localparam logic [3:0] VEC [10] = '{
    4'b0000, 4'b1000, 4'b0100, 4'b1010, 4'b0010,
    4'b1001, 4'b0000, 4'b1110, 4'b1000, 4'b0001
  };

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    check("R1 reset cpu", int'(cpu_clk_o), 0);
    check("R1 reset pci", int'(pci_clk_o), 0);
    drive(0, 0, 0, 0);
    rst = 1'b0;
    mon_on = 1'b1;

    foreach (VEC[k]) begin
      int cpu_hi, free_hi, gated_hi, mis, r, exp_free, exp_gated;
      drive(VEC[k][3], VEC[k][2], VEC[k][1], VEC[k][0]);
      repeat (12) cyc();
      cpu_hi = 0; free_hi = 0; gated_hi = 0; mis = 0;
      for (int c = 0; c < 12; c++) begin
        cyc();
        if (cpu_clk_o == 2'b11) cpu_hi++;
        if (pci_clk_o[0]) free_hi++;
        if (pci_clk_o[1]) gated_hi++;
        if (pci_clk_o[5:1] != {5{pci_clk_o[1]}}) mis++;
      end
      r = VEC[k][3] ? 3 : 2;
      exp_free  = VEC[k][0] ? 0 : 12 / r;
      exp_gated = (VEC[k][0] | VEC[k][1]) ? 0 : 12 / r;
      check((VEC[k][2] | VEC[k][0]) ? "R5 cpu parked" : "R5 cpu running",
            cpu_hi, (VEC[k][2] | VEC[k][0]) ? 0 : 12);
      check(VEC[k][0] ? "R7 free parked" : (VEC[k][3] ? "R3 free ratio" : "R2 free ratio"),
            free_hi, exp_free);
      check(VEC[k][1] ? "R6 gated parked" : "R10 gated ratio", gated_hi, exp_gated);
      check("R9 lanes aligned", mis, 0);
    end

    // R8: a control takes effect only after the synchronizer
    drive(0, 0, 0, 0);
    repeat (12) cyc();
    drive(0, 1, 0, 0);
    cyc();
    check("R8 cpu still on after 1 edge", int'(cpu_clk_o), 3);
    cyc();
    check("R8 cpu still on after 2 edges", int'(cpu_clk_o), 3);
    repeat (3) cyc();
    check("R5 cpu parked after sync", int'(cpu_clk_o), 0);

    // R4: ratio toggled rapidly never yields a double-width pulse
    drive(1, 0, 0, 0);
    for (int t = 0; t < 20; t++) begin
      drive(t[0], 0, 0, 0);
      cyc();
    end
    repeat (6) cyc();
    check("R4 no double pulse", doubles, 0);
    check("R8 no cpu runt", runts, 0);

    // R1: reset mid-run
    drive(0, 0, 0, 0);
    rst = 1'b1;
    repeat (2) cyc();
    check("R1 reset mid-run cpu", int'(cpu_clk_o), 0);
    check("R1 reset mid-run pci", int'(pci_clk_o), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule